// File: doc/BRIEF.md
# UART Receive Character Queue with Packed Status Word

This block sits between a UART deserializer and a processor bus on the receive side. Each incoming character arrives on a one-cycle valid strobe with three error flags (framing, break, parity). The character and its flags are stored together in a small first-in, first-out store. The processor reads one 16-bit word. That word holds the oldest stored character, that character's error flags, the sticky overrun indication and three occupancy flags.

There are two read strobes. The popping read returns the word and retires the oldest entry. The peek read returns the same word and leaves the queue untouched, so polling software can look at the status without consuming data. A read strobe in cycle N makes `rd_word` carry the word as it stood in cycle N, from cycle N+1 onward. `rd_word` keeps that value until the next strobe.

Three occupancy conditions (nearly full, half full, data ready) can each drive the interrupt line through their own enable input.

Top module: `uart_rx_queue`

## Requirements
- R1: A strobe on `rd_pop` in cycle N, with the queue not empty, loads `rd_word` with the current word in cycle N+1 and removes the oldest entry. Entries come out in arrival order.
- R2: A strobe on `rd_peek` alone loads `rd_word` with the current word the same way, and leaves contents, order, occupancy and overrun unchanged.
- R3: The nearly-full flag is 1 exactly when occupancy is at least DEPTH-1, meaning at most one free slot remains.
- R4: The half flag is 1 exactly when occupancy is at least DEPTH/2 (four or more with DEPTH=8).
- R5: The data-ready flag is 1 exactly when occupancy is one or more.
- R6: Word layout, with bit 15 as the MSB:
  - [15] nearly full
  - [14] half
  - [13] data ready
  - [12] reserved, always 0
  - [11] overrun
  - [10] framing error
  - [9] break
  - [8] parity error
  - [7:0] character
  
  Bits [10:0] are meaningful only when data ready is 1.
- R7: After synchronous reset, `rd_word` is 0, the queue is empty, overrun is 0 and `irq` is 0 with every enable set.
- R8: `irq` is the OR of nearly-full AND `ie_full`, half AND `ie_half`, and data-ready AND `ie_ready`. It follows the enables in the same cycle.
- R9: A character that arrives while occupancy is DEPTH, with no popping read in that cycle, is discarded and sets the sticky overrun bit. The next popping read still reports overrun=1 and then clears it.
- R10: When a character and a popping read come in the same cycle, both take effect and occupancy is unchanged. This holds at full occupancy too, where no overrun results.
- R11: A popping read of an empty queue changes neither contents nor occupancy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Character strobe from the deserializer |
| in_char | input | DATA_W | Received character |
| in_frame_err | input | 1 | Framing error of this character |
| in_break | input | 1 | Break condition with this character |
| in_parity_err | input | 1 | Parity error of this character |
| rd_pop | input | 1 | Popping read strobe |
| rd_peek | input | 1 | Non-destructive read strobe |
| ie_full | input | 1 | Interrupt enable, nearly-full condition |
| ie_half | input | 1 | Interrupt enable, half condition |
| ie_ready | input | 1 | Interrupt enable, data-ready condition |
| rd_word | output | DATA_W+8 | Registered read word |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with its defaults, DATA_W=8 and DEPTH=8. With eight slots, every occupancy from 0 to 8 can be reached in a handful of cycles, so each flag threshold is checked on both sides of its boundary. The overflow drop and its sticky flag need only nine pushes. Simultaneous push and pop at full occupancy can be forced directly, and a long pseudo-random mix of pushes, pops and peeks repeatedly crosses every threshold and the wrap of the pointers.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

  typedef struct packed {
    logic frm;
    logic brk;
    logic par;
  } rxq_err_t;

  typedef struct packed {
    logic full;
    logic half;
    logic ready;
  } rxq_lvl_t;

  localparam int unsigned LVL_N = 3;

endpackage

// File: rtl/rxq_store.sv
module rxq_store #(
  parameter int unsigned ENT_W  = 11,
  parameter int unsigned DEPTH  = 8,
  localparam int unsigned ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [ENT_W-1:0]  wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [ENT_W-1:0]  rd_data
);

  // Plain array with no reset: maps to distributed RAM.
  logic [ENT_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  assign rd_data = mem[rd_addr];

endmodule

// File: rtl/rxq_ctrl.sv
module rxq_ctrl
  import rxq_pkg::*;
#(
  parameter int unsigned DEPTH  = 8,
  localparam int unsigned ADDR_W = $clog2(DEPTH),
  localparam int unsigned CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push,
  input  logic              pop,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [ADDR_W-1:0] rd_addr,
  output rxq_lvl_t          lvl,
  output logic              ovr,
  output logic [CNT_W-1:0]  count
);

  localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] CNT_HALF = CNT_W'(DEPTH / 2);

  logic [ADDR_W-1:0] wp_q, rp_q;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              do_pop, do_push, drop, room;

  assign do_pop  = pop && (cnt_q != '0);
  assign room    = (cnt_q != CNT_MAX) || do_pop;
  assign do_push = push && room;
  assign drop    = push && !room;
  assign cnt_d   = cnt_q + CNT_W'(do_push) - CNT_W'(do_pop);

  always_ff @(posedge clk) begin
    if (rst) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
      ovr   <= 1'b0;
      lvl   <= '0;
    end else begin
      if (do_push) wp_q <= wp_q + 1'b1;
      if (do_pop)  rp_q <= rp_q + 1'b1;
      cnt_q <= cnt_d;
      if (drop)        ovr <= 1'b1;
      else if (do_pop) ovr <= 1'b0;
      lvl.full  <= (cnt_d >= CNT_FULL);
      lvl.half  <= (cnt_d >= CNT_HALF);
      lvl.ready <= (cnt_d != '0);
    end
  end

  assign wr_en   = do_push;
  assign wr_addr = wp_q;
  assign rd_addr = rp_q;
  assign count   = cnt_q;

  // R1: a pop without a push lowers occupancy by one
  a_r1_pop_dec: assert property (@(posedge clk) disable iff (rst)
    (pop && !push && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

  // R3/R4/R5: flags track occupancy
  a_r3_full_flag: assert property (@(posedge clk) disable iff (rst)
    lvl.full == (cnt_q >= CNT_FULL));
  a_r4_half_flag: assert property (@(posedge clk) disable iff (rst)
    lvl.half == (cnt_q >= CNT_HALF));
  a_r5_ready_flag: assert property (@(posedge clk) disable iff (rst)
    lvl.ready == (cnt_q != '0));

  // R9: occupancy never exceeds DEPTH; an arrival at full sets overrun
  a_r9_no_overflow: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CNT_MAX);
  a_r9_ovr_set: assert property (@(posedge clk) disable iff (rst)
    (push && !pop && cnt_q == CNT_MAX) |=> (ovr && $stable(cnt_q)));

  // R10: simultaneous push and pop keeps occupancy
  a_r10_push_pop: assert property (@(posedge clk) disable iff (rst)
    (push && pop && cnt_q != '0) |=> $stable(cnt_q));

  // R11: pop on empty leaves occupancy alone
  a_r11_empty_pop: assert property (@(posedge clk) disable iff (rst)
    (pop && !push && cnt_q == '0) |=> (cnt_q == '0));

endmodule

// File: rtl/uart_rx_queue.sv
module uart_rx_queue
  import rxq_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DEPTH  = 8,
  localparam int unsigned WORD_W = DATA_W + 8,
  localparam int unsigned ENT_W  = DATA_W + 3,
  localparam int unsigned ADDR_W = $clog2(DEPTH),
  localparam int unsigned CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_char,
  input  logic              in_frame_err,
  input  logic              in_break,
  input  logic              in_parity_err,
  input  logic              rd_pop,
  input  logic              rd_peek,
  input  logic              ie_full,
  input  logic              ie_half,
  input  logic              ie_ready,
  output logic [WORD_W-1:0] rd_word,
  output logic              irq
);

  logic              wr_en;
  logic [ADDR_W-1:0] wr_addr, rd_addr;
  logic [ENT_W-1:0]  wr_ent, head_ent;
  rxq_lvl_t          lvl;
  rxq_err_t          in_err, head_err;
  logic              ovr;
  logic [CNT_W-1:0]  count;
  logic [WORD_W-1:0] word_now;

  assign in_err = '{frm: in_frame_err, brk: in_break, par: in_parity_err};
  assign wr_ent = {in_err, in_char};

  rxq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .push   (in_valid),
    .pop    (rd_pop),
    .wr_en  (wr_en),
    .wr_addr(wr_addr),
    .rd_addr(rd_addr),
    .lvl    (lvl),
    .ovr    (ovr),
    .count  (count)
  );

  rxq_store #(.ENT_W(ENT_W), .DEPTH(DEPTH)) u_store (
    .clk    (clk),
    .wr_en  (wr_en),
    .wr_addr(wr_addr),
    .wr_data(wr_ent),
    .rd_addr(rd_addr),
    .rd_data(head_ent)
  );

  assign head_err = head_ent[ENT_W-1 -: 3];
  assign word_now = {lvl.full, lvl.half, lvl.ready, 1'b0, ovr,
                     head_err.frm, head_err.brk, head_err.par,
                     head_ent[DATA_W-1:0]};

  always_ff @(posedge clk) begin
    if (rst)                  rd_word <= '0;
    else if (rd_pop || rd_peek) rd_word <= word_now;
  end

  // Interrupt: one gated term per fill condition
  logic [LVL_N-1:0] cond, en, hit;
  assign cond = {lvl.full, lvl.half, lvl.ready};
  assign en   = {ie_full, ie_half, ie_ready};

  for (genvar g = 0; g < LVL_N; g++) begin : g_irq
    assign hit[g] = cond[g] & en[g];
  end

  assign irq = |hit;

  // R2: a peek alone leaves occupancy and overrun unchanged
  a_r2_peek_hold: assert property (@(posedge clk) disable iff (rst)
    (rd_peek && !rd_pop && !in_valid) |=> ($stable(count) && $stable(ovr)));

  // R1/R2: a read strobe captures the pre-edge word
  a_r1_word_capture: assert property (@(posedge clk) disable iff (rst)
    (rd_pop || rd_peek) |=> (rd_word == $past(word_now)));

  // R6: reserved bit of the word is never set after a read
  a_r6_reserved: assert property (@(posedge clk) disable iff (rst)
    $past(rd_pop || rd_peek) |-> (rd_word[WORD_W-4] == 1'b0));

  // R9: a pop with overrun set clears it
  a_r9_ovr_clear: assert property (@(posedge clk) disable iff (rst)
    (rd_pop && ovr && count != '0) |=> !ovr);

endmodule

// File: tb/uart_rx_queue_tb.sv
module uart_rx_queue_tb;

  localparam int CLK_P  = 10;
  localparam int DATA_W = 8;
  localparam int DEPTH  = 8;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              in_valid = 1'b0;
  logic [DATA_W-1:0] in_char = '0;
  logic              in_frame_err = 1'b0, in_break = 1'b0, in_parity_err = 1'b0;
  logic              rd_pop = 1'b0, rd_peek = 1'b0;
  logic              ie_full = 1'b0, ie_half = 1'b0, ie_ready = 1'b0;
  logic [15:0]       rd_word;
  logic              irq;

  always #(CLK_P/2) clk = ~clk;

  uart_rx_queue #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_char(in_char),
    .in_frame_err(in_frame_err), .in_break(in_break), .in_parity_err(in_parity_err),
    .rd_pop(rd_pop), .rd_peek(rd_peek), .ie_full(ie_full), .ie_half(ie_half),
    .ie_ready(ie_ready), .rd_word(rd_word), .irq(irq)
  );

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  // Reference model: {frm,brk,par,char}
  logic [10:0] mdl[$];
  bit          m_ovr = 0;

  // Scoreboard queues
  logic [15:0] sb_w[$];
  logic [15:0] sb_m[$];
  string       sb_t[$];
  bit          fired = 0;

  function automatic logic [15:0] exp_word();
    logic [15:0] w;
    int n = mdl.size();
    w = '0;
    w[15] = (n >= DEPTH-1);
    w[14] = (n >= DEPTH/2);
    w[13] = (n > 0);
    w[11] = m_ovr;
    if (n > 0) w[10:0] = mdl[0];
    return w;
  endfunction

  task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // Driver: at a negedge, apply one cycle of stimulus
  task automatic op(input bit psh, input logic [10:0] e, input bit pop, input bit pk,
                    input string tag);
    in_valid = psh;
    {in_frame_err, in_break, in_parity_err, in_char} = e;
    rd_pop = pop;
    rd_peek = pk;
    if (pop || pk) begin
      sb_w.push_back(exp_word());
      sb_m.push_back(mdl.size() > 0 ? 16'hFFFF : 16'hF800);
      sb_t.push_back(tag);
    end
    if (pop && mdl.size() > 0) begin
      void'(mdl.pop_front());
      m_ovr = 0;
    end
    if (psh) begin
      if (mdl.size() < DEPTH) mdl.push_back(e);
      else m_ovr = 1;
    end
    @(posedge clk);
    @(negedge clk);
    in_valid = 0; rd_pop = 0; rd_peek = 0;
  endtask

  // Monitor
  always @(posedge clk) fired <= (rd_pop || rd_peek) && !rst;
  always @(negedge clk) begin
    if (fired) begin
      if (sb_w.size() == 0) begin
        n_chk++; n_bad++;
        $display("FAIL R1: unexpected read result %h expected none", rd_word);
      end else begin
        logic [15:0] ew, em;
        string t;
        ew = sb_w.pop_front(); em = sb_m.pop_front(); t = sb_t.pop_front();
        check(t, rd_word & em, ew & em);
      end
    end
  end

  task automatic chk_irq(input logic [2:0] en, input string tag);
    int n = mdl.size();
    logic ex;
    {ie_full, ie_half, ie_ready} = en;
    #1;
    ex = (en[2] && n >= DEPTH-1) || (en[1] && n >= DEPTH/2) || (en[0] && n > 0);
    check(tag, {15'd0, irq}, {15'd0, ex});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    // R7: reset state
    check("R7 word", rd_word, 16'h0000);
    chk_irq(3'b111, "R7 irq");
    op(0, '0, 0, 1, "R7 R5 peek empty");

    // R3 R4 R5 R8 at every occupancy, with R2 peeks
    for (int i = 0; i <= DEPTH; i++) begin
      op(0, '0, 0, 1, "R3 R4 R5 R6 peek");
      op(0, '0, 0, 1, "R2 second peek");
      chk_irq(3'b100, "R8 full en");
      chk_irq(3'b010, "R8 half en");
      chk_irq(3'b001, "R8 ready en");
      chk_irq(3'b000, "R8 none en");
      if (i < DEPTH) op(1, {i[2:0], 8'hA0 + 8'(i)}, 0, 0, "push");
    end

    // R9: overflow drops and sets sticky flag
    op(1, 11'h7EE, 0, 0, "R9 drop");
    op(0, '0, 0, 1, "R9 ovr visible");
    op(1, 11'h7DD, 0, 0, "R9 drop again");
    for (int i = 0; i < DEPTH; i++) op(0, '0, 1, 0, "R1 R9 drain");
    op(0, '0, 0, 1, "R9 ovr cleared");

    // R11: pop on empty ignored
    op(0, '0, 1, 0, "R11 empty pop");
    op(1, 11'h05A, 0, 0, "push");
    op(0, '0, 0, 1, "R11 contents");

    // R10: push with pop at full and mid occupancy
    for (int i = 0; i < DEPTH-1; i++) op(1, {3'b101, 8'h30 + 8'(i)}, 0, 0, "push");
    op(1, 11'h3C1, 1, 0, "R10 full push pop");
    op(0, '0, 0, 1, "R10 no overrun");
    for (int i = 0; i < 5; i++) op(0, '0, 1, 0, "R1 pop");
    op(1, 11'h2B2, 1, 0, "R10 mid push pop");
    op(0, '0, 0, 1, "R10 count kept");

    // Mixed pseudo-random traffic
    lfsr = 16'hACE1;
    for (int k = 0; k < 600; k++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      op(lfsr[0] | lfsr[1], lfsr[12:2], lfsr[3] & lfsr[5], lfsr[7] & ~(lfsr[3] & lfsr[5]),
         "R1 R2 R9 R10 mix");
    end
    for (int i = 0; i <= DEPTH; i++) op(0, '0, 1, 0, "R1 final drain");
    op(0, '0, 0, 1, "R5 empty end");
    chk_irq(3'b111, "R8 empty end");

    repeat (2) @(negedge clk);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule